// File: doc/BRIEF.md
# Superscalar Dispatch Throttle

This block sits between the instruction fetch stream and the out-of-order back end and decides, one head instruction per clock, whether that instruction may be dispatched. A machine cycle is opened by the `cyc_start` strobe. On that strobe the block refills a per-cycle micro-op budget of `WIDTH` slots, less any debt left over from earlier cycles. Each dispatch then draws its micro-op count from that budget. An instruction that needs more micro-ops than the budget still holding is let through anyway. The shortfall becomes carry-over debt, and later refills pay it off, so a very wide instruction takes the dispatch bandwidth of the cycles that follow.

Admission is gated by three resource checks, tested in a fixed order. First comes the retire buffer: it must have free slots for the micro-op count, with that count clamped to the buffer size. Next the physical register files must all be free, which means the busy mask is zero. Last the scheduler must accept. The first check that fails blocks the dispatch and sets a two-bit stall cause. On a dispatch, the block reports how many physical registers the instruction allocates. An instruction marked zero-latency and dependency-breaking allocates none. The drained indication follows the retire buffer's empty status.

Budget control is a two-state machine. In SPENT no slots remain and nothing can dispatch until the next `cyc_start`. In OPEN some slots remain. The transitions are as follows. OPEN-to-SPENT happens on a dispatch that uses the last slot or runs past it. SPENT-to-OPEN happens on a refill that leaves slots. OPEN-to-OPEN happens on a partial dispatch or an idle clock. SPENT-to-SPENT happens on a clock with no refill, or on a refill fully eaten by debt. Reset enters SPENT.

Top module: `dispatch_throttle`

## Requirements
- R1: After reset, and until the first `cyc_start`, `slots_left` and `carry_pending` are 0 and nothing dispatches even with `inst_valid` high.
- R2: In a `cyc_start` clock the effective budget `slots_left` is 0 if the prior debt is at least `WIDTH`, and otherwise `WIDTH` minus the debt. In the same clock the debt is reduced by `WIDTH`, saturating at 0.
- R3: A dispatch with `inst_uops` not above `slots_left` leaves `slots_left - inst_uops` for the next clock of the same cycle. No dispatch happens while `slots_left` is 0.
- R4: A dispatch with `inst_uops` above `slots_left` still happens. It sets the remaining budget to 0 and adds `inst_uops - slots_left` to `carry_pending` on the next clock.
- R5: The retire check passes when `rob_free` is at least min(`inst_uops`, `ROB_SIZE`). A failure gives stall cause 2'b01.
- R6: With the retire check passing, a nonzero `rf_busy` mask (one bit per register file) gives stall cause 2'b10.
- R7: With both earlier checks passing, `sched_ok` low gives stall cause 2'b11. With all three passing, the instruction dispatches.
- R8: `stall_cause` is 2'b00 when an instruction dispatches, when `inst_valid` is low, and when `slots_left` is 0.
- R9: On a dispatch, `alloc_regs` equals `inst_dsts`, or 0 when `inst_zero_lat` is set. It is 0 whenever nothing dispatches.
- R10: `drained` is high exactly when `rob_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Opens a machine cycle and refills the budget |
| inst_valid | input | 1 | A head instruction is offered |
| inst_uops | input | UOP_W | Micro-op count of the head instruction, at least 1 |
| inst_dsts | input | DST_W | Destination register count |
| inst_zero_lat | input | 1 | Zero-latency, dependency-breaking instruction |
| rob_free | input | ROB_W | Free retire-buffer slots |
| rf_busy | input | NRF | Per-register-file full mask |
| sched_ok | input | 1 | Scheduler can accept the instruction |
| rob_empty | input | 1 | Retire buffer holds no entries |
| disp_fire | output | 1 | Instruction dispatched this clock |
| stall_cause | output | 2 | 00 none, 01 retire buffer, 10 register file, 11 scheduler |
| alloc_regs | output | DST_W | Physical registers allocated by this dispatch |
| slots_left | output | SLOT_W | Effective budget this clock |
| carry_pending | output | CARRY_W | Debt carried from earlier cycles |
| drained | output | 1 | Back end drained |

## Verification
The bench sweeps every pair of micro-op counts for back-to-back dispatches within one cycle. This covers exact budget exhaustion, oversize dispatch and multi-cycle debt payoff. A design that refilled the budget without subtracting debt, or that failed to saturate it, would show wrong `slots_left` on later refills. A design that refused oversize instructions would stall forever. A full grid over retire-buffer room, busy masks and scheduler acceptance targets the check ordering and the clamp of micro-op counts above the buffer size. Swapping the order of two checks changes the reported cause. Dropping the clamp stalls a seven-micro-op instruction against a full, empty buffer. The zero-latency sweep catches register allocation that ignores the flag.

// File: rtl/dt_pkg.sv
package dt_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_ROB   = 2'b01,
        CAUSE_RF    = 2'b10,
        CAUSE_SCHED = 2'b11
    } stall_cause_e;

    typedef enum logic {
        ST_SPENT = 1'b0,
        ST_OPEN  = 1'b1
    } budget_state_e;

endpackage

// File: rtl/dt_budget.sv
module dt_budget
    import dt_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int UOP_W  = 3,
    parameter int BW     = 3,
    parameter int CW     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             fire,
    input  logic [UOP_W-1:0] uops,
    output logic [BW-1:0]    slots_eff,
    output logic [CW-1:0]    carry_q
);
    localparam int SW = ((CW > BW) ? CW : BW) + 2;

    budget_state_e state_q, state_n;
    logic [BW-1:0] avail_q, avail_n;
    logic [CW-1:0] carry_n;
    logic [SW-1:0] carry_x, width_x, uops_x;
    logic [SW-1:0] ref_slots, ref_carry, slots_x, use_carry;

    // refill arithmetic and budget consumption
    always_comb begin
        carry_x = SW'(carry_q);
        width_x = SW'(WIDTH);
        uops_x  = SW'(uops);
        if (carry_x >= width_x) begin
            ref_slots = '0;
            ref_carry = carry_x - width_x;
        end else begin
            ref_slots = width_x - carry_x;
            ref_carry = '0;
        end

        slots_x   = '0;
        use_carry = carry_x;
        if (cyc_start) begin
            slots_x   = ref_slots;
            use_carry = ref_carry;
        end else begin
            unique case (state_q)
                ST_OPEN:  slots_x = SW'(avail_q);
                ST_SPENT: slots_x = '0;
                default:  slots_x = '0;
            endcase
        end

        if (fire && (uops_x > slots_x)) begin
            avail_n = '0;
            carry_n = CW'(use_carry + uops_x - slots_x);
        end else if (fire) begin
            avail_n = BW'(slots_x - uops_x);
            carry_n = CW'(use_carry);
        end else begin
            avail_n = BW'(slots_x);
            carry_n = CW'(use_carry);
        end

        state_n = (avail_n != '0) ? ST_OPEN : ST_SPENT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SPENT;
            avail_q <= '0;
            carry_q <= '0;
        end else begin
            state_q <= state_n;
            avail_q <= avail_n;
            carry_q <= carry_n;
        end
    end

    assign slots_eff = BW'(slots_x);

endmodule

// File: rtl/dt_admit.sv
module dt_admit
    import dt_pkg::*;
#(
    parameter int UOP_W    = 3,
    parameter int ROB_SIZE = 6,
    parameter int ROB_W    = 3,
    parameter int NRF      = 2
) (
    input  logic             req,
    input  logic [UOP_W-1:0] uops,
    input  logic [ROB_W-1:0] rob_free,
    input  logic [NRF-1:0]   rf_busy,
    input  logic             sched_ok,
    output logic             go,
    output stall_cause_e     cause
);
    localparam int SW = ((UOP_W > ROB_W) ? UOP_W : ROB_W) + 2;

    logic [SW-1:0] need_x;
    logic          rob_ok;

    always_comb begin
        need_x = (SW'(uops) > SW'(ROB_SIZE)) ? SW'(ROB_SIZE) : SW'(uops);
        rob_ok = SW'(rob_free) >= need_x;
        go     = 1'b0;
        cause  = CAUSE_NONE;
        if (req) begin
            if (!rob_ok) begin
                cause = CAUSE_ROB;
            end else if (rf_busy != '0) begin
                cause = CAUSE_RF;
            end else if (!sched_ok) begin
                cause = CAUSE_SCHED;
            end else begin
                go = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dispatch_throttle.sv
module dispatch_throttle
    import dt_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter int UOP_W    = 3,
    parameter int DST_W    = 2,
    parameter int NRF      = 2,
    parameter int ROB_SIZE = 6,
    parameter int ROB_W    = $clog2(ROB_SIZE + 1),
    parameter int SLOT_W   = $clog2(WIDTH + 1),
    parameter int CARRY_W  = UOP_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               inst_valid,
    input  logic [UOP_W-1:0]   inst_uops,
    input  logic [DST_W-1:0]   inst_dsts,
    input  logic               inst_zero_lat,
    input  logic [ROB_W-1:0]   rob_free,
    input  logic [NRF-1:0]     rf_busy,
    input  logic               sched_ok,
    input  logic               rob_empty,
    output logic               disp_fire,
    output logic [1:0]         stall_cause,
    output logic [DST_W-1:0]   alloc_regs,
    output logic [SLOT_W-1:0]  slots_left,
    output logic [CARRY_W-1:0] carry_pending,
    output logic               drained
);
    logic         req;
    logic         go;
    stall_cause_e cause;

    dt_budget #(
        .WIDTH (WIDTH),
        .UOP_W (UOP_W),
        .BW    (SLOT_W),
        .CW    (CARRY_W)
    ) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .fire      (go),
        .uops      (inst_uops),
        .slots_eff (slots_left),
        .carry_q   (carry_pending)
    );

    assign req = inst_valid && (slots_left != '0);

    dt_admit #(
        .UOP_W    (UOP_W),
        .ROB_SIZE (ROB_SIZE),
        .ROB_W    (ROB_W),
        .NRF      (NRF)
    ) u_admit (
        .req      (req),
        .uops     (inst_uops),
        .rob_free (rob_free),
        .rf_busy  (rf_busy),
        .sched_ok (sched_ok),
        .go       (go),
        .cause    (cause)
    );

    always_comb begin
        disp_fire   = go;
        stall_cause = cause;
        alloc_regs  = (go && !inst_zero_lat) ? inst_dsts : '0;
        drained     = rob_empty;
    end

endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int WIDTH    = 4,
    parameter int UOP_W    = 3,
    parameter int DST_W    = 2,
    parameter int ROB_SIZE = 6,
    parameter int ROB_W    = 3,
    parameter int SLOT_W   = 3,
    parameter int CARRY_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_start,
    input logic               inst_valid,
    input logic [UOP_W-1:0]   inst_uops,
    input logic               inst_zero_lat,
    input logic [ROB_W-1:0]   rob_free,
    input logic               disp_fire,
    input logic [1:0]         stall_cause,
    input logic [DST_W-1:0]   alloc_regs,
    input logic [SLOT_W-1:0]  slots_left,
    input logic [CARRY_W-1:0] carry_pending
);
    // R8
    fire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> (stall_cause == 2'b00));

    // R3
    fire_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> (slots_left != '0));

    // R4
    spent_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && (int'(inst_uops) >= int'(slots_left)))
        |=> (cyc_start || (slots_left == '0)));

    // R2
    debt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && (int'(carry_pending) >= WIDTH))
        |-> ((slots_left == '0) && !disp_fire));

    // R9
    zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && inst_zero_lat) |-> (alloc_regs == '0));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_valid |-> (!disp_fire && (stall_cause == 2'b00)));

    // R5
    rob_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && (slots_left != '0)
         && (int'(rob_free) < int'(inst_uops)) && (int'(inst_uops) <= ROB_SIZE))
        |-> (stall_cause == 2'b01));

endmodule

bind dispatch_throttle dt_checker #(
    .WIDTH    (WIDTH),
    .UOP_W    (UOP_W),
    .DST_W    (DST_W),
    .ROB_SIZE (ROB_SIZE),
    .ROB_W    (ROB_W),
    .SLOT_W   (SLOT_W),
    .CARRY_W  (CARRY_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_start     (cyc_start),
    .inst_valid    (inst_valid),
    .inst_uops     (inst_uops),
    .inst_zero_lat (inst_zero_lat),
    .rob_free      (rob_free),
    .disp_fire     (disp_fire),
    .stall_cause   (stall_cause),
    .alloc_regs    (alloc_regs),
    .slots_left    (slots_left),
    .carry_pending (carry_pending)
);

// File: tb/dispatch_throttle_test.sv
`timescale 1ns/1ps
module dispatch_throttle_test;
    localparam int W  = 4;
    localparam int RS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       inst_valid = 1'b0;
    logic [2:0] inst_uops = 3'd1;
    logic [1:0] inst_dsts = 2'd0;
    logic       inst_zero_lat = 1'b0;
    logic [2:0] rob_free = 3'd0;
    logic [1:0] rf_busy = 2'd0;
    logic       sched_ok = 1'b0;
    logic       rob_empty = 1'b0;
    logic       disp_fire;
    logic [1:0] stall_cause;
    logic [1:0] alloc_regs;
    logic [2:0] slots_left;
    logic [3:0] carry_pending;
    logic       drained;

    int n_run = 0;
    int n_bad = 0;
    int m_avail = 0;
    int m_carry = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dispatch_throttle #(.WIDTH(W), .UOP_W(3), .DST_W(2), .NRF(2), .ROB_SIZE(RS)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .inst_valid(inst_valid),
        .inst_uops(inst_uops), .inst_dsts(inst_dsts), .inst_zero_lat(inst_zero_lat),
        .rob_free(rob_free), .rf_busy(rf_busy), .sched_ok(sched_ok), .rob_empty(rob_empty),
        .disp_fire(disp_fire), .stall_cause(stall_cause), .alloc_regs(alloc_regs),
        .slots_left(slots_left), .carry_pending(carry_pending), .drained(drained)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit cs, input bit v, input int u, input int d, input bit z,
                        input int rf, input int mask, input bit s, input bit e);
        int ea, ec, need, ecause, efire;
        @(negedge clk);
        cyc_start = cs; inst_valid = v; inst_uops = 3'(u); inst_dsts = 2'(d);
        inst_zero_lat = z; rob_free = 3'(rf); rf_busy = 2'(mask); sched_ok = s; rob_empty = e;
        #1;
        chk("R2 carry before refill", int'(carry_pending), m_carry);
        ea = cs ? ((m_carry >= W) ? 0 : W - m_carry) : m_avail;
        ec = cs ? ((m_carry > W) ? m_carry - W : 0) : m_carry;
        need = (u > RS) ? RS : u;
        efire = 0; ecause = 0;
        if (v && ea > 0) begin
            if (rf < need)      ecause = 1;
            else if (mask != 0) ecause = 2;
            else if (!s)        ecause = 3;
            else                efire = 1;
        end
        chk("R2 R3 slots_left", int'(slots_left), ea);
        chk("R5 R6 R7 R8 stall_cause", int'(stall_cause), ecause);
        chk("R3 R4 R7 disp_fire", int'(disp_fire), efire);
        chk("R9 alloc_regs", int'(alloc_regs), (efire == 1 && !z) ? d : 0);
        chk("R10 drained", int'(drained), int'(e));
        if (efire == 1) begin
            if (u > ea) begin m_avail = 0; m_carry = ec + u - ea; end
            else begin m_avail = ea - u; m_carry = ec; end
        end else begin
            m_avail = ea; m_carry = ec;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 slots at reset", int'(slots_left), 0);
        chk("R1 carry at reset", int'(carry_pending), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no dispatch before first refill
        step(0, 1, 1, 1, 0, 6, 0, 1, 1);
        step(0, 1, 2, 1, 0, 6, 0, 1, 0);

        // R2 R3 R4: pairs of micro-op counts within one cycle, then debt payoff
        for (int a = 1; a <= 7; a++) begin
            for (int b = 1; b <= 7; b++) begin
                step(1, 1, a, 1, 0, 6, 0, 1, 0);
                step(0, 1, b, 2, 0, 6, 0, 1, 1);
                step(0, 0, 1, 0, 0, 6, 0, 1, 1);
                step(1, 1, 1, 3, 0, 6, 0, 1, 0);
                step(1, 1, 1, 0, 0, 6, 0, 1, 0);
                step(1, 0, 1, 0, 0, 6, 0, 1, 1);
                step(1, 0, 1, 0, 0, 6, 0, 1, 1);
            end
        end

        // R5 R6 R7 R8: ordered admission grid, clamp at ROB_SIZE
        for (int rf = 0; rf <= 6; rf++) begin
            for (int u = 1; u <= 7; u++) begin
                for (int m = 0; m <= 3; m++) begin
                    for (int s = 0; s <= 1; s++) begin
                        step(1, 0, 1, 0, 0, 6, 0, 1, 0);
                        step(1, 0, 1, 0, 0, 6, 0, 1, 0);
                        step(1, 1, u, 1, 0, rf, m, s[0], rf[0]);
                    end
                end
            end
        end

        // R9: zero-latency allocation
        for (int d = 0; d <= 3; d++) begin
            for (int z = 0; z <= 1; z++) begin
                step(1, 0, 1, 0, 0, 6, 0, 1, 0);
                step(1, 0, 1, 0, 0, 6, 0, 1, 0);
                step(1, 1, 2, d, z[0], 6, 0, 1, 1);
                step(0, 1, 1, d, z[0], 6, 0, 1, 0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule